// File: doc/BRIEF.md
# Timer Input Capture Channel

This block is one capture channel that sits beside a free-running timer count. It watches one of four selectable sources (two external input pins, a tied-low source and a tied-high source), resynchronises the pins into the timer clock domain and looks for a rising edge, a falling edge or either edge, as configured. When a qualifying edge arrives, the present timer value is stored in the channel's capture register and a capture flag is raised. This flag can drive an interrupt line.

Software reaches the channel through a small register port with two addresses: a control/status word and the capture value. Reading the capture value marks it as consumed. If a second capture lands while the earlier value is still unread, a sticky overflow bit is set. An optional synchronise mode holds a detected edge until the next cycle in which the timer tick enable is high, so that the stored value lines up with a timer increment. Software uses the stored stamps to work out periods and pulse widths.

Top module: `tcap_channel`

## Requirements
- R1: After reset, the control word reads 0, the capture value reads 0 and `irq` is low.
- R2: Edge field, control bits [1:0]: 00 captures nothing, 01 captures on rising edges only, 10 on falling edges only, 11 on both.
- R3: Source field, control bits [3:2]: 00 selects `src_a`, 01 selects `src_b`, 10 a constant 0 and 11 a constant 1. An unselected pin never causes a capture.
- R4: On a capture, the capture value (address 1) takes the value of `timer_val` and the flag (control bit 6) is set. With synchronise off, this happens within three clock edges of an input change.
- R5: A capture that occurs while the previous capture value has not been read sets the overflow bit (control bit 7). Reading address 1 with `rd_en` marks the value as read, so the next capture does not set overflow.
- R6: The flag and the overflow bit are cleared only by writing 0 to that bit of the control word. Writing 1 leaves the bit unchanged.
- R7: With synchronise (control bit 4) set, a detected edge is held until a cycle in which `timer_tick` is high. It is then captured with the `timer_val` of that cycle. No capture occurs while `timer_tick` stays low.
- R8: Control bit 8 (read-only) shows the level of the currently selected source after synchronisation.
- R9: Changing the source field does not by itself cause a capture, even when the old and new source levels differ.
- R10: `irq` is high exactly when the flag is set and the interrupt enable (control bit 5) is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Synchronous active-low reset |
| timer_val | input | CNT_W | Current count of the timer |
| timer_tick | input | 1 | High in cycles where the timer advances |
| src_a | input | 1 | External capture input A (asynchronous) |
| src_b | input | 1 | External capture input B (asynchronous) |
| wr_en | input | 1 | Write strobe for the control word |
| rd_en | input | 1 | Read strobe; at address 1 it consumes the capture value |
| addr | input | 1 | 0 selects the control/status word, 1 selects the capture value |
| wdata | input | 8 | Write data for the control word |
| rdata | output | CNT_W | Read data for the addressed word |
| irq | output | 1 | Interrupt request |

## Verification
If the edge-history state is wrong, a spurious capture or a missing capture appears at the ports: the flag bit changes and `irq` follows within three cycles of an input change or a source switch. If the unread tracking is wrong, the overflow bit shows a wrong value on the next capture after a read or a missed read. If the held-edge state in synchronise mode is wrong, the capture value carries the timer count of the wrong cycle, or the flag rises before any tick. The scoreboard pairs every expected stamp with the next capture-register read, so a capture lost or added shifts every value after it.

// File: rtl/tcap_pkg.sv
// Shared encodings and field positions for the capture channel.
// Assumes the read data width (CNT_W) is at least 9 bits.
package tcap_pkg;

    localparam int CTRL_W = 8;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_mode_e;

    typedef enum logic [1:0] {
        SRC_PIN_A = 2'b00,
        SRC_PIN_B = 2'b01,
        SRC_LOW   = 2'b10,
        SRC_HIGH  = 2'b11
    } src_sel_e;

    localparam int BIT_SYNC  = 4;
    localparam int BIT_IE    = 5;
    localparam int BIT_FLAG  = 6;
    localparam int BIT_OVF   = 7;
    localparam int BIT_LEVEL = 8;

endpackage

// File: rtl/tcap_sync.sv
// Two-flop synchroniser bank, one chain per asynchronous input.
// Assumes the inputs are single-bit levels without pulse-width guarantees.
module tcap_sync #(
    parameter int N_IN   = 2,
    parameter int STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_IN-1:0] async_in,
    output logic [N_IN-1:0] sync_out
);

    genvar gi;
    generate
        for (gi = 0; gi < N_IN; gi++) begin : g_chain
            logic [STAGES-1:0] stage_q;
            // Shift the raw level through the flop chain.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q <= '0;
                else        stage_q <= {stage_q[STAGES-2:0], async_in[gi]};
            end
            assign sync_out[gi] = stage_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/tcap_edge.sv
// Source selection and edge qualification.
// Keeps the previous selected level; during the cycle after a source
// change the comparison is suppressed, so a switch alone yields no edge.
module tcap_edge
    import tcap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lvl_a,
    input  logic       lvl_b,
    input  src_sel_e   src_sel,
    input  edge_mode_e edge_sel,
    input  logic       src_switch,
    output logic       sel_level,
    output logic       edge_hit
);

    logic prev_q;
    logic rise;
    logic fall;

    // Pick the level of the configured source.
    always_comb begin
        unique case (src_sel)
            SRC_PIN_A: sel_level = lvl_a;
            SRC_PIN_B: sel_level = lvl_b;
            SRC_LOW:   sel_level = 1'b0;
            default:   sel_level = 1'b1;
        endcase
    end

    // Remember the last level seen, to compare against.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sel_level;
    end

    assign rise = sel_level & ~prev_q;
    assign fall = ~sel_level & prev_q;

    // Qualify the transition against the configured edge sense.
    always_comb begin
        unique case (edge_sel)
            EDGE_RISE: edge_hit = rise;
            EDGE_FALL: edge_hit = fall;
            EDGE_BOTH: edge_hit = rise | fall;
            default:   edge_hit = 1'b0;
        endcase
        if (src_switch) edge_hit = 1'b0;
    end

endmodule

// File: rtl/tcap_capture.sv
// Capture register, flag, overflow and unread tracking, plus the
// hold-until-tick path for synchronised captures.
// Assumes at most one detected edge is kept pending.
module tcap_capture #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] timer_val,
    input  logic             timer_tick,
    input  logic             edge_hit,
    input  logic             sync_en,
    input  logic             rd_cap,
    input  logic             clr_flag,
    input  logic             clr_ovf,
    output logic             cap_pulse,
    output logic [CNT_W-1:0] cap_val,
    output logic             flag,
    output logic             ovf
);

    logic pending_q;
    logic unread_q;

    assign cap_pulse = (edge_hit & (~sync_en | timer_tick))
                     | (pending_q & sync_en & timer_tick);

    // Hold a detected edge until the next tick in synchronise mode.
    always_ff @(posedge clk) begin
        if (!rst_n)                      pending_q <= 1'b0;
        else if (!sync_en)               pending_q <= 1'b0;
        else if (edge_hit && !timer_tick) pending_q <= 1'b1;
        else if (timer_tick)             pending_q <= 1'b0;
    end

    // Store the stamp and keep the flag, overflow and unread state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_val  <= '0;
            flag     <= 1'b0;
            ovf      <= 1'b0;
            unread_q <= 1'b0;
        end else if (cap_pulse) begin
            cap_val  <= timer_val;
            flag     <= 1'b1;
            unread_q <= 1'b1;
            if (unread_q && !rd_cap) ovf <= 1'b1;
            else if (clr_ovf)        ovf <= 1'b0;
        end else begin
            if (clr_flag) flag     <= 1'b0;
            if (clr_ovf)  ovf      <= 1'b0;
            if (rd_cap)   unread_q <= 1'b0;
        end
    end

endmodule

// File: rtl/tcap_channel.sv
// Top of the capture channel: control register, write/read decode,
// and wiring of synchroniser, edge qualifier and capture store.
// Assumes CNT_W >= 9 so the status bits fit in the read word.
module tcap_channel
    import tcap_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  timer_val,
    input  logic              timer_tick,
    input  logic              src_a,
    input  logic              src_b,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              addr,
    input  logic [CTRL_W-1:0] wdata,
    output logic [CNT_W-1:0]  rdata,
    output logic              irq
);

    edge_mode_e       edge_sel;
    src_sel_e         src_sel;
    logic             sync_en;
    logic             irq_en;
    logic             src_switch;
    logic             ctrl_wr;
    logic             rd_cap;
    logic [1:0]       lvl_sync;
    logic             sel_level;
    logic             edge_hit;
    logic             cap_pulse;
    logic [CNT_W-1:0] cap_val;
    logic             flag;
    logic             ovf;

    assign ctrl_wr = wr_en & ~addr;
    assign rd_cap  = rd_en & addr;

    // Control fields and the one-cycle source-change marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edge_sel   <= EDGE_NONE;
            src_sel    <= SRC_PIN_A;
            sync_en    <= 1'b0;
            irq_en     <= 1'b0;
            src_switch <= 1'b0;
        end else begin
            src_switch <= ctrl_wr && (src_sel_e'(wdata[3:2]) != src_sel);
            if (ctrl_wr) begin
                edge_sel <= edge_mode_e'(wdata[1:0]);
                src_sel  <= src_sel_e'(wdata[3:2]);
                sync_en  <= wdata[BIT_SYNC];
                irq_en   <= wdata[BIT_IE];
            end
        end
    end

    tcap_sync #(.N_IN(2), .STAGES(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({src_b, src_a}),
        .sync_out (lvl_sync)
    );

    tcap_edge u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .lvl_a      (lvl_sync[0]),
        .lvl_b      (lvl_sync[1]),
        .src_sel    (src_sel),
        .edge_sel   (edge_sel),
        .src_switch (src_switch),
        .sel_level  (sel_level),
        .edge_hit   (edge_hit)
    );

    tcap_capture #(.CNT_W(CNT_W)) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .timer_val  (timer_val),
        .timer_tick (timer_tick),
        .edge_hit   (edge_hit),
        .sync_en    (sync_en),
        .rd_cap     (rd_cap),
        .clr_flag   (ctrl_wr & ~wdata[BIT_FLAG]),
        .clr_ovf    (ctrl_wr & ~wdata[BIT_OVF]),
        .cap_pulse  (cap_pulse),
        .cap_val    (cap_val),
        .flag       (flag),
        .ovf        (ovf)
    );

    // Read multiplexer for the two addresses.
    always_comb begin
        rdata = '0;
        if (addr) begin
            rdata = cap_val;
        end else begin
            rdata[1:0]       = edge_sel;
            rdata[3:2]       = src_sel;
            rdata[BIT_SYNC]  = sync_en;
            rdata[BIT_IE]    = irq_en;
            rdata[BIT_FLAG]  = flag;
            rdata[BIT_OVF]   = ovf;
            rdata[BIT_LEVEL] = sel_level;
        end
    end

    assign irq = flag & irq_en;

endmodule

// File: rtl/tcap_channel_chk.sv
// Protocol checker for the capture channel, attached by bind.
module tcap_channel_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] timer_val,
    input logic             timer_tick,
    input logic             wr_en,
    input logic             addr,
    input logic [7:0]       wdata,
    input logic [1:0]       edge_sel,
    input logic             sync_en,
    input logic             src_switch,
    input logic             edge_hit,
    input logic             cap_pulse,
    input logic [CNT_W-1:0] cap_val,
    input logic             flag,
    input logic             ovf
);

    // R4: a capture stores the timer value of its cycle and raises the flag
    assert_cap_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cap_pulse |=> (cap_val == $past(timer_val)) && flag);

    // R2: with no edge sense selected no edge qualifies
    assert_no_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_sel == 2'b00) |-> !edge_hit);

    // R9: the cycle after a source change yields no edge
    assert_switch_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        src_switch |-> !edge_hit);

    // R7: synchronised captures happen only in tick cycles
    assert_sync_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_pulse && sync_en) |-> timer_tick);

    // R6: overflow stays set unless written to zero
    assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !(wr_en && !addr && !wdata[7])) |=> ovf);

    // R6: flag stays set unless written to zero
    assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !(wr_en && !addr && !wdata[6])) |=> flag);

endmodule

bind tcap_channel tcap_channel_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .timer_val  (timer_val),
    .timer_tick (timer_tick),
    .wr_en      (wr_en),
    .addr       (addr),
    .wdata      (wdata),
    .edge_sel   (edge_sel),
    .sync_en    (sync_en),
    .src_switch (src_switch),
    .edge_hit   (edge_hit),
    .cap_pulse  (cap_pulse),
    .cap_val    (cap_val),
    .flag       (flag),
    .ovf        (ovf)
);

// File: tb/tcap_channel_tb.sv
module tcap_channel_tb;

    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [CNT_W-1:0] timer_val = '0;
    logic             timer_tick = 1'b0;
    logic             src_a = 1'b0;
    logic             src_b = 1'b0;
    logic             wr_en = 1'b0;
    logic             rd_en = 1'b0;
    logic             addr = 1'b0;
    logic [7:0]       wdata = '0;
    logic [CNT_W-1:0] rdata;
    logic             irq;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;
    logic [CNT_W-1:0] exp_q[$];
    event mon_ev;

    always #4 clk = ~clk;

    tcap_channel #(.CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .timer_val(timer_val), .timer_tick(timer_tick),
        .src_a(src_a), .src_b(src_b), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [CNT_W-1:0] act,
                         input logic [CNT_W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: compare each capture-register read with the scoreboard.
    always @(mon_ev) begin
        if (exp_q.size() == 0) check("R4 unexpected read", rdata, 'x);
        else check("R4 capture stamp", rdata, exp_q.pop_front());
    end

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Control word: edge, src, sync, ie, keep-flag, keep-ovf.
    task automatic wr_ctrl(input logic [1:0] e, input logic [1:0] s, input logic sy,
                           input logic ie, input logic kf, input logic ko);
        @(negedge clk);
        wr_en = 1'b1; addr = 1'b0; wdata = {ko, kf, ie, sy, s, e};
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic peek_ctrl(output logic [CNT_W-1:0] v);
        @(negedge clk);
        addr = 1'b0;
        #1 v = rdata;
    endtask

    // Driver: apply an input level at the given timer value, push the expected stamp.
    task automatic drive_edge(input bit on_b, input logic lvl,
                              input logic [CNT_W-1:0] tv, input bit expect_cap);
        @(negedge clk);
        timer_val = tv;
        if (on_b) src_b = lvl; else src_a = lvl;
        if (expect_cap) exp_q.push_back(tv);
        wait_n(4);
    endtask

    task automatic read_cap();
        @(negedge clk);
        addr = 1'b1; rd_en = 1'b1;
        #1 -> mon_ev;
        @(negedge clk);
        rd_en = 1'b0; addr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [CNT_W-1:0] v;
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);
        // R1 reset state
        peek_ctrl(v); check("R1 ctrl", v, 0);
        addr = 1'b1; #1 check("R1 cap value", rdata, 0);
        check("R1 irq", {15'b0, irq}, 0);

        // R4/R10: rising capture on A with interrupt enabled
        wr_ctrl(2'b01, 2'b00, 0, 1, 0, 0);
        drive_edge(0, 1, 16'h1234, 1);
        peek_ctrl(v); check("R4 flag set", {15'b0, v[6]}, 1);
        check("R8 level A high", {15'b0, v[8]}, 1);
        check("R10 irq with enable", {15'b0, irq}, 1);
        read_cap();

        // R2: rising-only ignores a falling edge
        wr_ctrl(2'b01, 2'b00, 0, 1, 0, 0);
        drive_edge(0, 0, 16'h2222, 0);
        peek_ctrl(v); check("R2 rise ignores fall", {15'b0, v[6]}, 0);
        check("R10 irq low when flag clear", {15'b0, irq}, 0);

        // R2: falling-only
        wr_ctrl(2'b10, 2'b00, 0, 0, 0, 0);
        drive_edge(0, 1, 16'h2a2a, 0);
        peek_ctrl(v); check("R2 fall ignores rise", {15'b0, v[6]}, 0);
        drive_edge(0, 0, 16'h3333, 1);
        peek_ctrl(v); check("R2 fall captures", {15'b0, v[6]}, 1);
        check("R10 irq masked", {15'b0, irq}, 0);
        read_cap();

        // R2: both edges
        wr_ctrl(2'b11, 2'b00, 0, 0, 0, 0);
        drive_edge(0, 1, 16'h4444, 1);
        read_cap();
        drive_edge(0, 0, 16'h5555, 1);
        read_cap();
        peek_ctrl(v); check("R5 no overflow after reads", {15'b0, v[7]}, 0);

        // R5: overflow on unread second capture
        drive_edge(0, 1, 16'h6000, 0);
        drive_edge(0, 0, 16'h6001, 1);
        peek_ctrl(v); check("R5 overflow set", {15'b0, v[7]}, 1);
        read_cap();
        // R6: writing 1 keeps, writing 0 clears
        wr_ctrl(2'b11, 2'b00, 0, 0, 1, 1);
        peek_ctrl(v); check("R6 overflow kept by write 1", {15'b0, v[7]}, 1);
        check("R6 flag kept by write 1", {15'b0, v[6]}, 1);
        wr_ctrl(2'b11, 2'b00, 0, 0, 0, 0);
        peek_ctrl(v); check("R6 overflow cleared", {15'b0, v[7]}, 0);
        check("R6 flag cleared", {15'b0, v[6]}, 0);
        drive_edge(0, 1, 16'h6100, 1);
        peek_ctrl(v); check("R5 consumed read avoids overflow", {15'b0, v[7]}, 0);
        read_cap();

        // R3: source B; pin A ignored
        wr_ctrl(2'b11, 2'b01, 0, 0, 0, 0);
        wait_n(2);
        wr_ctrl(2'b11, 2'b01, 0, 0, 0, 0);
        drive_edge(0, 0, 16'h6200, 0);
        peek_ctrl(v); check("R3 unselected A ignored", {15'b0, v[6]}, 0);
        drive_edge(1, 1, 16'h6300, 1);
        peek_ctrl(v); check("R8 level B high", {15'b0, v[8]}, 1);
        read_cap();
        drive_edge(1, 0, 16'h6400, 1);
        read_cap();

        // R3/R9: constant sources
        wr_ctrl(2'b11, 2'b10, 0, 0, 0, 0);
        wait_n(3);
        peek_ctrl(v); check("R3 const low level", {15'b0, v[8]}, 0);
        wr_ctrl(2'b11, 2'b11, 0, 0, 0, 0);
        wait_n(3);
        peek_ctrl(v); check("R3 const high level", {15'b0, v[8]}, 1);
        check("R9 switch to high no capture", {15'b0, v[6]}, 0);
        wr_ctrl(2'b11, 2'b00, 0, 0, 0, 0);
        wait_n(3);
        peek_ctrl(v); check("R9 switch to A no capture", {15'b0, v[6]}, 0);

        // R7: synchronised capture waits for tick
        wr_ctrl(2'b11, 2'b00, 1, 0, 0, 0);
        @(negedge clk); timer_val = 16'h7000; src_a = 1'b1;
        wait_n(6);
        peek_ctrl(v); check("R7 no capture before tick", {15'b0, v[6]}, 0);
        @(negedge clk); timer_val = 16'h7777; timer_tick = 1'b1;
        exp_q.push_back(16'h7777);
        @(negedge clk); timer_tick = 1'b0; timer_val = 16'h7800;
        wait_n(1);
        peek_ctrl(v); check("R7 capture on tick", {15'b0, v[6]}, 1);
        read_cap();

        wait_n(2);
        check("R4 scoreboard drained", exp_q.size(), 0);
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule